// File: doc/BRIEF.md
# EDO Dynamic Memory Cycle Decoder

This block models, in synthesizable form, the control side of a 1M x 16 extended-data-out dynamic memory. A fast reference clock samples the active-low strobes: row strobe, lower and upper byte column strobes, write enable and output enable. It also samples a 12-bit multiplexed address bus and the write data. Edges are found by comparing each sample with the one before it. From the order in which the strobes move, the block works out which cycle a memory controller is running. It latches the row and column addresses, writes or reads a small storage array, and drives the 16-bit read data together with a per-byte output enable.

The memory is addressed as 4096 rows of 256 columns. The storage array keeps only a parameterised slice of that space. It is indexed by the low `ARR_ROW_BITS` bits of the row and the low `ARR_COL_BITS` bits of the column, 4 and 4 by default, so addresses that differ only in higher bits alias. Refresh cycles do not touch the array. They appear as a one-cycle pulse together with the row that was refreshed, and an internal counter supplies the row for strobe-ordered refresh.

Top module: `edo_dram_ctl`

## Requirements
- R1: After reset, `dq_oe` is 00, `cyc_type` is 0 (idle) and `rfsh_pulse` is low.
- R2: With the row strobe low, a byte column strobe low, write enable high and output enable low in a read cycle (`cyc_type` 1), the stored word at the latched row and column is presented on `dq_out`.
- R3: `lcas_n` governs data bits 7:0 and `dq_oe[0]`. `ucas_n` governs bits 15:8 and `dq_oe[1]`. A cycle with one column strobe active reads or writes only that byte, and the other stored byte is unchanged.
- R4: If write enable is already low when the first column strobe falls, the cycle is an early write (`cyc_type` 2). The sampled data is stored and `dq_oe` stays 00.
- R5: If write enable falls after a column strobe while no output was driven in that column cycle, the cycle becomes a delayed write (`cyc_type` 3). The data present when write enable falls is stored.
- R6: If data was driven in the column cycle and write enable then falls, the cycle becomes read-modify-write (`cyc_type` 4). The outputs turn off and the new data is stored.
- R7: A row strobe pulse with both column strobes high gives `cyc_type` 5 while the row strobe is low. When the row strobe rises, a one-cycle `rfsh_pulse` is issued with `rfsh_row` equal to the row address, and no output is driven.
- R8: A falling row strobe while either column strobe (even only one) is already low gives `cyc_type` 6. It issues `rfsh_pulse` with `rfsh_row` equal to a 12-bit counter that starts at 0 after reset and advances by one per such cycle. No write takes place in this cycle.
- R9: After the column strobes rise with the row strobe still low, the driven data and `dq_oe` are held. They are released when output enable goes high, or when the row strobe and both column strobes are high.
- R10: With the row strobe and both column strobes high, `cyc_type` returns to 0 and `dq_oe` is 00.
- R11: Within one row strobe low period, each new first-falling column strobe latches a fresh column and reads the word stored there (page mode).
- R12: The cycle mode and the column are taken at the earliest falling column strobe. A second byte strobe falling later in the same column cycle joins that mode at the latched column, even if the address bus has changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 12 | Multiplexed row/column address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe | output | 2 | Per-byte output drive enable, bit 0 lower byte |
| cyc_type | output | 3 | Decoded cycle: 0 idle, 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 strobe-ordered refresh |
| rfsh_pulse | output | 1 | One-cycle pulse per completed refresh |
| rfsh_row | output | 12 | Row refreshed, valid with the pulse |

## Verification
The assertions check on every cycle that:
- a byte's output enable only turns on when that byte's sampled column strobe is low and write enable is high;
- outputs go quiet one cycle after all strobes are seen high;
- the refresh counter advances with each strobe-ordered refresh;
- no array write occurs during such a refresh.

Only the directed scenarios can show that stored values come back correctly. They also show that early, delayed and read-modify-write cycles are told apart by strobe order, that a late second byte strobe lands at the first latched column, and that data is held after the column strobes rise.

// File: rtl/edo_pkg.sv
// Package: shared strobe indices and cycle type encoding for the EDO
// cycle decoder. Assumes strobe vectors are ordered as listed below.
package edo_pkg;
    localparam int IDX_RAS  = 0;
    localparam int IDX_LCAS = 1;
    localparam int IDX_UCAS = 2;
    localparam int IDX_WE   = 3;
    localparam int IDX_OE   = 4;
    localparam int NSTRB    = 5;

    typedef enum logic [2:0] {
        CYC_IDLE   = 3'd0,
        CYC_READ   = 3'd1,
        CYC_EWRITE = 3'd2,
        CYC_DWRITE = 3'd3,
        CYC_RMW    = 3'd4,
        CYC_ROR    = 3'd5,
        CYC_CBR    = 3'd6
    } cyc_e;
endpackage

// File: rtl/edo_strobe_sync.sv
// Module: edo_strobe_sync
// Samples the asynchronous strobes, address and data on the reference
// clock and flags falling and rising strobe edges against the previous
// sample. Assumes strobes are held for several clock periods.
module edo_strobe_sync #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int NS     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NS-1:0]     strb_raw,
    input  logic [ADDR_W-1:0] addr_raw,
    input  logic [DATA_W-1:0] din_raw,
    output logic [NS-1:0]     s_strb,
    output logic [NS-1:0]     p_strb,
    output logic [NS-1:0]     fall,
    output logic [NS-1:0]     rise,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_din
);
    genvar gi;
    generate
        for (gi = 0; gi < NS; gi++) begin : g_strb
            // Two-deep history of one strobe, reset to inactive (high).
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s_strb[gi] <= 1'b1;
                    p_strb[gi] <= 1'b1;
                end else begin
                    s_strb[gi] <= strb_raw[gi];
                    p_strb[gi] <= s_strb[gi];
                end
            end
            assign fall[gi] = p_strb[gi] & ~s_strb[gi];
            assign rise[gi] = ~p_strb[gi] & s_strb[gi];
        end
    endgenerate

    // Sample the address and write data alongside the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_addr <= '0;
            s_din  <= '0;
        end else begin
            s_addr <= addr_raw;
            s_din  <= din_raw;
        end
    end
endmodule

// File: rtl/edo_cycle_fsm.sv
// Module: edo_cycle_fsm
// Decodes the cycle type from strobe ordering, latches row and column,
// produces per-byte write enables and refresh pulses, and keeps the
// refresh row counter. Assumes sampled strobes from edo_strobe_sync.
module edo_cycle_fsm
    import edo_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 8,
    parameter int NBYTE  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSTRB-1:0]  s_strb,
    input  logic [NSTRB-1:0]  p_strb,
    input  logic [NSTRB-1:0]  fall,
    input  logic [NSTRB-1:0]  rise,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic              out_drv,
    output cyc_e              cyc_q,
    output logic [ADDR_W-1:0] row_q,
    output logic [COL_W-1:0]  col_q,
    output logic [COL_W-1:0]  wr_col,
    output logic [NBYTE-1:0]  wr_be,
    output logic              rd_en,
    output logic              rfsh_pulse_q,
    output logic [ADDR_W-1:0] rfsh_row_q,
    output logic [ADDR_W-1:0] cbr_ctr
);
    logic             ras_low, ras_fall, ras_rise, we_fall, we_low;
    logic [NBYTE-1:0] byte_low, byte_fall;
    logic             any_cas, prev_cas, cas_start;
    logic             rd_seen;

    // Decode active levels and edges from the sampled strobes.
    always_comb begin
        ras_low   = ~s_strb[IDX_RAS];
        ras_fall  = fall[IDX_RAS];
        ras_rise  = rise[IDX_RAS];
        we_low    = ~s_strb[IDX_WE];
        we_fall   = fall[IDX_WE];
        byte_low  = {~s_strb[IDX_UCAS], ~s_strb[IDX_LCAS]};
        byte_fall = {fall[IDX_UCAS], fall[IDX_LCAS]};
        any_cas   = |byte_low;
        prev_cas  = ~p_strb[IDX_UCAS] | ~p_strb[IDX_LCAS];
        cas_start = any_cas & ~prev_cas & ras_low & ~ras_fall & (cyc_q != CYC_CBR);
    end

    // Column used by a write: the bus value on the first edge, else latched.
    assign wr_col = cas_start ? s_addr[COL_W-1:0] : col_q;

    // Per-byte write enables: strobe falls with WE low, or WE falls under a low strobe.
    genvar gb;
    generate
        for (gb = 0; gb < NBYTE; gb++) begin : g_we
            assign wr_be[gb] = ras_low & ~ras_fall & (cyc_q != CYC_CBR) &
                               ((byte_fall[gb] & we_low) | (we_fall & byte_low[gb]));
        end
    endgenerate

    // Reads are allowed once the column has settled in a read-type cycle.
    assign rd_en = ras_low & ~cas_start & ((cyc_q == CYC_READ) || (cyc_q == CYC_RMW));

    // Cycle state, address latches, refresh pulse and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q        <= CYC_IDLE;
            row_q        <= '0;
            col_q        <= '0;
            rfsh_pulse_q <= 1'b0;
            rfsh_row_q   <= '0;
            cbr_ctr      <= '0;
        end else begin
            rfsh_pulse_q <= 1'b0;
            if (ras_fall) begin
                if (any_cas) begin
                    cyc_q        <= CYC_CBR;
                    rfsh_pulse_q <= 1'b1;
                    rfsh_row_q   <= cbr_ctr;
                    cbr_ctr      <= cbr_ctr + 1'b1;
                end else begin
                    cyc_q <= CYC_ROR;
                    row_q <= s_addr;
                end
            end else if (ras_rise && cyc_q == CYC_ROR) begin
                rfsh_pulse_q <= 1'b1;
                rfsh_row_q   <= row_q;
                cyc_q        <= CYC_IDLE;
            end else if (cas_start) begin
                col_q <= s_addr[COL_W-1:0];
                cyc_q <= we_low ? CYC_EWRITE : CYC_READ;
            end else if (ras_low && we_fall && any_cas && cyc_q == CYC_READ) begin
                cyc_q <= rd_seen ? CYC_RMW : CYC_DWRITE;
            end else if (!ras_low && !any_cas) begin
                cyc_q <= CYC_IDLE;
            end
        end
    end

    // Remembers whether data was driven in the current column cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_seen <= 1'b0;
        else if (cas_start) rd_seen <= 1'b0;
        else if (out_drv)   rd_seen <= 1'b1;
    end
endmodule

// File: rtl/edo_cell_array.sv
// Module: edo_cell_array
// Small synthesizable storage standing in for the cell array, with one
// write enable per byte lane and an asynchronous read port. Row and
// column are folded to their low bits, so the wider space aliases.
module edo_cell_array #(
    parameter int ADDR_W       = 12,
    parameter int COL_W        = 8,
    parameter int DATA_W       = 16,
    parameter int ARR_ROW_BITS = 4,
    parameter int ARR_COL_BITS = 4
) (
    input  logic                  clk,
    input  logic [DATA_W/8-1:0]   wr_be,
    input  logic [ADDR_W-1:0]     wr_row,
    input  logic [COL_W-1:0]      wr_col,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_row,
    input  logic [COL_W-1:0]      rd_col,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int NBYTE = DATA_W / 8;
    localparam int IDX_W = ARR_ROW_BITS + ARR_COL_BITS;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [IDX_W-1:0]  wr_idx, rd_idx;

    assign wr_idx  = {wr_row[ARR_ROW_BITS-1:0], wr_col[ARR_COL_BITS-1:0]};
    assign rd_idx  = {rd_row[ARR_ROW_BITS-1:0], rd_col[ARR_COL_BITS-1:0]};
    assign rd_data = cells[rd_idx];

    genvar gb;
    generate
        for (gb = 0; gb < NBYTE; gb++) begin : g_lane
            // Write one byte lane of the addressed word.
            always_ff @(posedge clk) begin
                if (wr_be[gb]) cells[wr_idx][gb*8 +: 8] <= wr_data[gb*8 +: 8];
            end
        end
    endgenerate
endmodule

// File: rtl/edo_out_ctl.sv
// Module: edo_out_ctl
// Per-byte output data register and drive enable. It loads data while a
// read is allowed, holds it after the column strobe rises (extended data
// out), and releases it on OE high or on full standby.
module edo_out_ctl #(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W/8-1:0] byte_low,
    input  logic                ras_high,
    input  logic                we_high,
    input  logic                oe_high,
    input  logic                rd_en,
    input  logic [DATA_W-1:0]   rd_data,
    output logic [DATA_W-1:0]   dout_q,
    output logic [DATA_W/8-1:0] oe_q
);
    localparam int NBYTE = DATA_W / 8;

    logic release_all;
    assign release_all = oe_high | (ras_high & ~(|byte_low));

    genvar gb;
    generate
        for (gb = 0; gb < NBYTE; gb++) begin : g_lane
            // Drive, hold or release one output byte.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    oe_q[gb]            <= 1'b0;
                    dout_q[gb*8 +: 8]   <= '0;
                end else if (release_all) begin
                    oe_q[gb]            <= 1'b0;
                end else if (byte_low[gb] && rd_en && we_high) begin
                    oe_q[gb]            <= 1'b1;
                    dout_q[gb*8 +: 8]   <= rd_data[gb*8 +: 8];
                end else if (byte_low[gb] && !we_high) begin
                    oe_q[gb]            <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/edo_dram_ctl.sv
// Module: edo_dram_ctl (top)
// Clock-sampled EDO dynamic memory control model: strobe sampling, cycle
// decode, storage and byte-wise output control. Assumes the reference
// clock is much faster than the strobe timing.
module edo_dram_ctl
    import edo_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int COL_W        = 8,
    parameter int DATA_W       = 16,
    parameter int ARR_ROW_BITS = 4,
    parameter int ARR_COL_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              lcas_n,
    input  logic              ucas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic [1:0]        dq_oe,
    output logic [2:0]        cyc_type,
    output logic              rfsh_pulse,
    output logic [ADDR_W-1:0] rfsh_row
);
    localparam int NBYTE = DATA_W / 8;

    logic [NSTRB-1:0]  strb_raw, s_strb, p_strb, fall, rise;
    logic [ADDR_W-1:0] s_addr, row_q, cbr_ctr;
    logic [DATA_W-1:0] s_din, rd_data;
    logic [COL_W-1:0]  col_q, wr_col;
    logic [NBYTE-1:0]  wr_be, oe_q;
    logic              rd_en;
    cyc_e              cyc_q;

    // Pack the raw strobes in package index order.
    always_comb begin
        strb_raw           = '1;
        strb_raw[IDX_RAS]  = ras_n;
        strb_raw[IDX_LCAS] = lcas_n;
        strb_raw[IDX_UCAS] = ucas_n;
        strb_raw[IDX_WE]   = we_n;
        strb_raw[IDX_OE]   = oe_n;
    end

    edo_strobe_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NS(NSTRB)) u_sync (
        .clk(clk), .rst_n(rst_n), .strb_raw(strb_raw), .addr_raw(addr),
        .din_raw(dq_in), .s_strb(s_strb), .p_strb(p_strb), .fall(fall),
        .rise(rise), .s_addr(s_addr), .s_din(s_din)
    );

    edo_cycle_fsm #(.ADDR_W(ADDR_W), .COL_W(COL_W), .NBYTE(NBYTE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .s_strb(s_strb), .p_strb(p_strb),
        .fall(fall), .rise(rise), .s_addr(s_addr), .out_drv(|oe_q),
        .cyc_q(cyc_q), .row_q(row_q), .col_q(col_q), .wr_col(wr_col),
        .wr_be(wr_be), .rd_en(rd_en), .rfsh_pulse_q(rfsh_pulse),
        .rfsh_row_q(rfsh_row), .cbr_ctr(cbr_ctr)
    );

    edo_cell_array #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W),
                     .ARR_ROW_BITS(ARR_ROW_BITS), .ARR_COL_BITS(ARR_COL_BITS)) u_cells (
        .clk(clk), .wr_be(wr_be), .wr_row(row_q), .wr_col(wr_col),
        .wr_data(s_din), .rd_row(row_q), .rd_col(col_q), .rd_data(rd_data)
    );

    edo_out_ctl #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .byte_low({~s_strb[IDX_UCAS], ~s_strb[IDX_LCAS]}),
        .ras_high(s_strb[IDX_RAS]), .we_high(s_strb[IDX_WE]),
        .oe_high(s_strb[IDX_OE]), .rd_en(rd_en), .rd_data(rd_data),
        .dout_q(dq_out), .oe_q(oe_q)
    );

    assign dq_oe    = oe_q;
    assign cyc_type = cyc_q;
endmodule

// File: rtl/edo_dram_chk.sv
// Module: edo_dram_chk
// Property checker bound into edo_dram_ctl; observes sampled strobes,
// output enables, write enables and refresh state.
module edo_dram_chk
    import edo_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSTRB-1:0]  s_strb,
    input logic [1:0]        dq_oe,
    input logic [2:0]        cyc_type,
    input logic [1:0]        wr_be,
    input logic              rfsh_pulse,
    input logic [ADDR_W-1:0] rfsh_row,
    input logic [ADDR_W-1:0] cbr_ctr
);
    // R10
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_strb[IDX_RAS] && s_strb[IDX_LCAS] && s_strb[IDX_UCAS]) |=> (dq_oe == 2'b00));

    // R3
    low_lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe[0]) |-> !$past(s_strb[IDX_LCAS]));

    // R3
    high_lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe[1]) |-> !$past(s_strb[IDX_UCAS]));

    // R4
    drive_needs_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dq_oe[0]) || $rose(dq_oe[1])) |-> $past(s_strb[IDX_WE]));

    // R8
    cbr_counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_pulse && cyc_type == CYC_CBR) |-> (cbr_ctr == rfsh_row + 1'b1));

    // R8
    cbr_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_CBR) |-> (wr_be == 2'b00));
endmodule

bind edo_dram_ctl edo_dram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_strb(s_strb), .dq_oe(dq_oe),
    .cyc_type(cyc_type), .wr_be(wr_be), .rfsh_pulse(rfsh_pulse),
    .rfsh_row(rfsh_row), .cbr_ctr(cbr_ctr)
);

// File: tb/edo_dram_ctl_tb.sv
`timescale 1ns/1ps
module edo_dram_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic [2:0]  cyc_type;
    logic        rfsh_pulse;
    logic [11:0] rfsh_row;

    int n_tests = 0;
    int n_fail  = 0;
    int n_pulse = 0;
    logic [11:0] last_row = '0;
    logic [11:0] exp_ctr = '0;
    bit done = 0;

    always #4 clk = ~clk;

    edo_dram_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .cyc_type(cyc_type), .rfsh_pulse(rfsh_pulse), .rfsh_row(rfsh_row)
    );

    // Catch refresh pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rfsh_pulse) begin
            n_pulse  <= n_pulse + 1;
            last_row <= rfsh_row;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic end_cycle();
        lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        settle();
        ras_n = 1'b1;
        settle();
    endtask

    // Early write of the lanes selected by be (bit0 lower, bit1 upper).
    task automatic do_write(input logic [11:0] row, input logic [11:0] col,
                            input logic [15:0] d, input logic [1:0] be);
        addr = row; settle();
        ras_n = 1'b0; settle();
        addr = col; dq_in = d; we_n = 1'b0; settle();
        lcas_n = ~be[0]; ucas_n = ~be[1]; settle();
        end_cycle();
    endtask

    // Read with the selected lanes; leaves outputs sampled into d/oe.
    task automatic do_read(input logic [11:0] row, input logic [11:0] col,
                           input logic [1:0] be, output logic [15:0] d, output logic [1:0] oe);
        addr = row; settle();
        ras_n = 1'b0; settle();
        addr = col; oe_n = 1'b0; settle();
        lcas_n = ~be[0]; ucas_n = ~be[1]; settle();
        d = dq_out; oe = dq_oe;
        end_cycle();
    endtask

    task automatic t_reset();
        chk("R1 dq_oe", dq_oe, 2'b00);
        chk("R1 cyc_type", cyc_type, 3'd0);
        chk("R1 rfsh_pulse", rfsh_pulse, 1'b0);
    endtask

    task automatic t_early_write_read();
        logic [15:0] d; logic [1:0] oe;
        addr = 12'h013; settle();
        ras_n = 1'b0; settle();
        addr = 12'h024; dq_in = 16'hA5C3; we_n = 1'b0; settle();
        lcas_n = 1'b0; ucas_n = 1'b0; settle();
        chk("R4 cyc early write", cyc_type, 3'd2);
        chk("R4 outputs open", dq_oe, 2'b00);
        end_cycle();
        do_read(12'h013, 12'h024, 2'b11, d, oe);
        chk("R2 word data", d, 16'hA5C3);
        chk("R2 word oe", oe, 2'b11);
    endtask

    task automatic t_byte_lanes();
        logic [15:0] d; logic [1:0] oe;
        do_write(12'h031, 12'h005, 16'h1122, 2'b11);
        do_write(12'h031, 12'h005, 16'hEEFF, 2'b10);
        do_read(12'h031, 12'h005, 2'b11, d, oe);
        chk("R3 upper-only write", d, 16'hEE22);
        do_read(12'h031, 12'h005, 2'b01, d, oe);
        chk("R3 lower-only oe", oe, 2'b01);
        chk("R3 lower-only data", d[7:0], 8'h22);
    endtask

    task automatic t_delayed_write();
        logic [15:0] d; logic [1:0] oe;
        addr = 12'h042; settle();
        ras_n = 1'b0; settle();
        addr = 12'h007; settle();
        lcas_n = 1'b0; ucas_n = 1'b0; settle();
        chk("R5 read phase", cyc_type, 3'd1);
        dq_in = 16'h5AF0; we_n = 1'b0; settle();
        chk("R5 cyc delayed", cyc_type, 3'd3);
        end_cycle();
        do_read(12'h042, 12'h007, 2'b11, d, oe);
        chk("R5 stored", d, 16'h5AF0);
    endtask

    task automatic t_rmw();
        logic [15:0] d; logic [1:0] oe;
        do_write(12'h053, 12'h009, 16'h0F0F, 2'b11);
        addr = 12'h053; settle();
        ras_n = 1'b0; settle();
        addr = 12'h009; oe_n = 1'b0; settle();
        lcas_n = 1'b0; ucas_n = 1'b0; settle();
        chk("R6 read part data", dq_out, 16'h0F0F);
        oe_n = 1'b1; dq_in = 16'hBEEF; settle();
        we_n = 1'b0; settle();
        chk("R6 cyc rmw", cyc_type, 3'd4);
        chk("R6 outputs off", dq_oe, 2'b00);
        end_cycle();
        do_read(12'h053, 12'h009, 2'b11, d, oe);
        chk("R6 stored", d, 16'hBEEF);
    endtask

    task automatic t_ror();
        int p0;
        p0 = n_pulse;
        addr = 12'h5A3; settle();
        ras_n = 1'b0; settle();
        chk("R7 cyc ror", cyc_type, 3'd5);
        chk("R7 no output", dq_oe, 2'b00);
        ras_n = 1'b1; settle();
        chk("R7 pulse count", n_pulse, p0 + 1);
        chk("R7 row", last_row, 12'h5A3);
    endtask

    task automatic t_cbr(input logic lo_only);
        int p0;
        logic [15:0] d; logic [1:0] oe;
        p0 = n_pulse;
        if (lo_only) lcas_n = 1'b0; else ucas_n = 1'b0;
        we_n = 1'b0; dq_in = 16'hDEAD; addr = 12'h064;
        settle();
        ras_n = 1'b0; settle();
        chk("R8 cyc cbr", cyc_type, 3'd6);
        chk("R8 pulse count", n_pulse, p0 + 1);
        chk("R8 counter row", last_row, exp_ctr);
        exp_ctr = exp_ctr + 1'b1;
        ras_n = 1'b1; settle();
        lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; settle();
        do_read(12'h013, 12'h024, 2'b11, d, oe);
        chk("R8 no write", d, 16'hA5C3);
    endtask

    task automatic t_edo_hold();
        do_write(12'h071, 12'h00B, 16'h3C3C, 2'b11);
        addr = 12'h071; settle();
        ras_n = 1'b0; settle();
        addr = 12'h00B; oe_n = 1'b0; settle();
        lcas_n = 1'b0; ucas_n = 1'b0; settle();
        lcas_n = 1'b1; ucas_n = 1'b1; settle();
        chk("R9 hold oe", dq_oe, 2'b11);
        chk("R9 hold data", dq_out, 16'h3C3C);
        oe_n = 1'b1; settle();
        chk("R9 release on oe", dq_oe, 2'b00);
        oe_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; settle();
        lcas_n = 1'b1; ucas_n = 1'b1; settle();
        chk("R9 hold again", dq_oe, 2'b11);
        ras_n = 1'b1; settle();
        chk("R10 standby oe", dq_oe, 2'b00);
        chk("R10 standby cyc", cyc_type, 3'd0);
        oe_n = 1'b1; settle();
    endtask

    task automatic t_page();
        do_write(12'h082, 12'h001, 16'h1111, 2'b11);
        do_write(12'h082, 12'h002, 16'h2222, 2'b11);
        addr = 12'h082; settle();
        ras_n = 1'b0; settle();
        addr = 12'h001; oe_n = 1'b0; settle();
        lcas_n = 1'b0; ucas_n = 1'b0; settle();
        chk("R11 first column", dq_out, 16'h1111);
        lcas_n = 1'b1; ucas_n = 1'b1; addr = 12'h002; settle();
        lcas_n = 1'b0; ucas_n = 1'b0; settle();
        chk("R11 second column", dq_out, 16'h2222);
        end_cycle();
    endtask

    task automatic t_staggered();
        logic [15:0] d; logic [1:0] oe;
        do_write(12'h093, 12'h00E, 16'h7777, 2'b11);
        addr = 12'h093; settle();
        ras_n = 1'b0; settle();
        addr = 12'h00D; dq_in = 16'h9C4B; we_n = 1'b0; settle();
        lcas_n = 1'b0; settle();
        chk("R12 mode on first edge", cyc_type, 3'd2);
        addr = 12'h00E; settle();
        ucas_n = 1'b0; settle();
        end_cycle();
        do_read(12'h093, 12'h00D, 2'b11, d, oe);
        chk("R12 both lanes at first column", d, 16'h9C4B);
        do_read(12'h093, 12'h00E, 2'b11, d, oe);
        chk("R12 other column untouched", d, 16'h7777);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_early_write_read();
        t_byte_lanes();
        t_delayed_write();
        t_rmw();
        t_ror();
        t_cbr(1'b1);
        t_cbr(1'b0);
        t_edo_hold();
        t_page();
        t_staggered();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule